// File: doc/BRIEF.md
# Repeater Downstream Verification Controller

This controller runs the second authentication stage of a protected display link once the receiver has identified itself as a repeater. After a start pulse it polls the receiver for a key-list-ready flag, with one poll per millisecond tick, and gives up after a fixed number of milliseconds. It then reads the two-byte topology status and rejects a topology that is too deep, too wide or empty. Next it copies the downstream key list, byte by byte, into a local buffer. It reads the receiver's five-word V' value into compare registers and starts an external hash packer.

The hash packer, which lies outside this block, reads the buffered keys and the topology status and reports done and match. If the hash does not match, the controller reads V' again and retries, up to a set number of attempts. Any read error from the receiver ends the stage at once. The outcome stays on the ports as a pass flag and a three-bit error code until the next start.

Top module: `repeater_verify_ctrl`

## Requirements
- R1: After reset, busy, done, pass, rd_req and hash_start are 0 and err_code is 0.
- R2: rd_kind encodes 0 = ready poll, 1 = topology status, 2 = key byte, 3 = V' part. While rd_req is high and rd_ack is low, rd_req, rd_kind and rd_index hold their values.
- R3: A ready poll reads rd_data[0] as the ready flag. If the flag is 0, the next poll is issued only after an ms_tick. The first poll that returns 1 ends polling.
- R4: If TIMEOUT_MS polls in a row return not-ready, the stage ends on the following tick with err_code 1 and pass 0. Exactly TIMEOUT_MS polls are issued. A ready flag on poll number TIMEOUT_MS is still accepted.
- R5: Status byte 0 is rd_data[7:0] and byte 1 is rd_data[15:8]. If bit 7 of byte 0 (too many devices) or bit 3 of byte 1 (too deep) is set, or if the count is above MAX_KEYS, the stage ends with err_code 2, whatever the count. The other bits of byte 1 have no effect.
- R6: A device count (byte 0 bits 6:0) of zero ends the stage with err_code 3.
- R7: The controller issues exactly 5×count key reads, with rd_index 0 upward. Byte rd_data[7:0] of read i can be read back at kbuf_raddr = i. dev_count shows the count and status_word shows the two status bytes.
- R8: Each attempt reads V' parts with rd_index 0 to 4. Part i goes to v_prime[32i+31:32i]. After the fifth part, hash_start pulses for exactly one cycle.
- R9: When hash_done comes with hash_match = 0, all five V' parts are read again and the hash is restarted, for up to MAX_TRIES attempts in all. After MAX_TRIES mismatches the stage ends with err_code 4. A match ends it with pass = 1 and err_code 0.
- R10: A read answered with rd_err = 1 ends the stage on that cycle with err_code 5. No further read and no hash start follow.
- R11: busy is high from start until the end of the stage. done, pass and err_code then hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin the stage (sampled when not busy) |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| rd_req | output | 1 | Read request toward the receiver |
| rd_kind | output | 2 | What is read (see R2) |
| rd_index | output | 10 | Key byte index or V' part index |
| rd_ack | input | 1 | Read answered this cycle |
| rd_err | input | 1 | Read failed (valid with rd_ack) |
| rd_data | input | 32 | Read data (valid with rd_ack) |
| kbuf_raddr | input | 10 | Key buffer read address for the packer |
| kbuf_rdata | output | 8 | Key buffer read data |
| dev_count | output | 7 | Accepted downstream device count |
| status_word | output | 16 | Topology status bytes {byte1, byte0} |
| v_prime | output | 160 | V' compare registers |
| hash_start | output | 1 | Start pulse to the hash packer |
| hash_done | input | 1 | Hash packer finished |
| hash_match | input | 1 | Hash equals V' (valid with hash_done) |
| busy | output | 1 | Stage in progress |
| done | output | 1 | Stage finished |
| pass | output | 1 | Stage succeeded |
| err_code | output | 3 | 0 none, 1 timeout, 2 topology, 3 no devices, 4 mismatch, 5 read fault |

## Verification
A wrong internal state shows at the ports within one read transaction. An off-by-one in the key index shows up as a key read count that differs from 5×count, or as a mismatched byte in the buffer read-back, and both are checked at the end of the stage. A timer or attempt counter that is off by one shows up as the wrong number of polls or hash starts. A wrong branch in the rejection order shows up as the wrong error code, or as reads that continue after the stage should have stopped. The bench sweeps device counts, ready delays, mismatch counts, status bit combinations and error-injection points. It computes the expected counts and codes arithmetically.

// File: rtl/rdv_pkg.sv
package rdv_pkg;

   localparam int KEY_BYTES = 5;
   localparam int VP_PARTS  = 5;

   typedef enum logic [1:0] {
      RK_READY  = 2'd0,
      RK_STATUS = 2'd1,
      RK_KEY    = 2'd2,
      RK_VPART  = 2'd3
   } rd_kind_e;

   typedef enum logic [2:0] {
      EC_NONE       = 3'd0,
      EC_TIMEOUT    = 3'd1,
      EC_TOPOLOGY   = 3'd2,
      EC_NO_DEVICES = 3'd3,
      EC_MISMATCH   = 3'd4,
      EC_READ_FAULT = 3'd5
   } err_code_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_POLL,
      ST_WAIT,
      ST_STATUS,
      ST_KEY,
      ST_VPART,
      ST_HSTART,
      ST_HWAIT
   } state_e;

   typedef struct packed {
      logic       topo_bad;
      logic       no_dev;
      logic [6:0] count;
   } topo_t;

endpackage

// File: rtl/rdv_ms_timer.sv
module rdv_ms_timer #(
   parameter int LIMIT = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   output logic last
);
   localparam int CW = $clog2(LIMIT + 1);

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("rdv_ms_timer: LIMIT must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   assign last = (cnt == CW'(LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (clr)           cnt <= '0;
      else if (tick && !last) cnt <= cnt + 1'b1;
   end

   // R4
   tmr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < CW'(LIMIT));

endmodule

// File: rtl/rdv_topo_check.sv
module rdv_topo_check
   import rdv_pkg::*;
#(
   parameter int MAX_KEYS = 127
) (
   input  logic [7:0] byte0,
   input  logic       cascade_flag,
   output topo_t      topo
);
   always_comb begin
      topo.count    = byte0[6:0];
      topo.no_dev   = (byte0[6:0] == 7'd0);
      topo.topo_bad = byte0[7] | cascade_flag | (int'(byte0[6:0]) > MAX_KEYS);
   end
endmodule

// File: rtl/rdv_key_buffer.sv
module rdv_key_buffer #(
   parameter int DEPTH  = 635,
   parameter bit REG_RD = 1'b0,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [7:0]    wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [7:0]    rd_data
);
   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   generate
      if (REG_RD) begin : g_reg_rd
         logic [7:0] rd_q;
         always_ff @(posedge clk) rd_q <= mem[rd_addr];
         assign rd_data = rd_q;
      end else begin : g_comb_rd
         assign rd_data = mem[rd_addr];
      end
   endgenerate

   // R7
   kbuf_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(wr_addr) < DEPTH));

endmodule

// File: rtl/repeater_verify_ctrl.sv
module repeater_verify_ctrl
   import rdv_pkg::*;
#(
   parameter int MAX_KEYS    = 127,
   parameter int TIMEOUT_MS  = 5000,
   parameter int MAX_TRIES   = 3,
   parameter bit KBUF_REG_RD = 1'b0,
   localparam int DEPTH      = MAX_KEYS * KEY_BYTES,
   localparam int IDXW       = $clog2(DEPTH),
   localparam int TRYW       = $clog2(MAX_TRIES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              ms_tick,
   output logic              rd_req,
   output logic [1:0]        rd_kind,
   output logic [IDXW-1:0]   rd_index,
   input  logic              rd_ack,
   input  logic              rd_err,
   input  logic [31:0]       rd_data,
   input  logic [IDXW-1:0]   kbuf_raddr,
   output logic [7:0]        kbuf_rdata,
   output logic [6:0]        dev_count,
   output logic [15:0]       status_word,
   output logic [VP_PARTS*32-1:0] v_prime,
   output logic              hash_start,
   input  logic              hash_done,
   input  logic              hash_match,
   output logic              busy,
   output logic              done,
   output logic              pass,
   output logic [2:0]        err_code
);
   generate
      if (MAX_KEYS < 1 || MAX_KEYS > 127) begin : g_bad_keys
         $error("repeater_verify_ctrl: MAX_KEYS must be 1..127");
      end
      if (MAX_TRIES < 1) begin : g_bad_tries
         $error("repeater_verify_ctrl: MAX_TRIES must be at least 1");
      end
   endgenerate

   state_e            state;
   err_code_e         err_q;
   logic [IDXW-1:0]   idx;
   logic [2:0]        part;
   logic [TRYW-1:0]   tries;
   logic [6:0]        count_q;
   logic [15:0]       status_q;
   logic [VP_PARTS*32-1:0] vp_q;
   logic              done_q, pass_q;
   logic              tmr_last;
   logic              rd_ok, rd_bad;
   logic              kb_wr;
   logic [IDXW:0]     key_total;
   topo_t             topo;

   assign rd_ok  = rd_req && rd_ack && !rd_err;
   assign rd_bad = rd_req && rd_ack &&  rd_err;
   assign kb_wr  = (state == ST_KEY) && rd_ok;
   assign key_total = (IDXW+1)'(count_q) * (IDXW+1)'(KEY_BYTES);

   rdv_ms_timer #(.LIMIT(TIMEOUT_MS)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (state == ST_IDLE),
      .tick  ((state == ST_WAIT) && ms_tick),
      .last  (tmr_last)
   );

   rdv_topo_check #(.MAX_KEYS(MAX_KEYS)) u_topo (
      .byte0        (rd_data[7:0]),
      .cascade_flag (rd_data[11]),
      .topo         (topo)
   );

   rdv_key_buffer #(.DEPTH(DEPTH), .REG_RD(KBUF_REG_RD)) u_kbuf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (kb_wr),
      .wr_addr (idx),
      .wr_data (rd_data[7:0]),
      .rd_addr (kbuf_raddr),
      .rd_data (kbuf_rdata)
   );

   always_comb begin
      rd_req   = 1'b0;
      rd_kind  = RK_READY;
      rd_index = '0;
      case (state)
         ST_POLL:   begin rd_req = 1'b1; rd_kind = RK_READY;  end
         ST_STATUS: begin rd_req = 1'b1; rd_kind = RK_STATUS; end
         ST_KEY:    begin rd_req = 1'b1; rd_kind = RK_KEY;   rd_index = idx; end
         ST_VPART:  begin rd_req = 1'b1; rd_kind = RK_VPART; rd_index = IDXW'(part); end
         default:   ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         err_q    <= EC_NONE;
         idx      <= '0;
         part     <= '0;
         tries    <= '0;
         count_q  <= '0;
         status_q <= '0;
         vp_q     <= '0;
         done_q   <= 1'b0;
         pass_q   <= 1'b0;
      end else begin
         if (rd_bad) begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
            err_q  <= EC_READ_FAULT;
         end else begin
            case (state)
               ST_IDLE: if (start) begin
                  state  <= ST_POLL;
                  done_q <= 1'b0;
                  pass_q <= 1'b0;
                  err_q  <= EC_NONE;
                  idx    <= '0;
                  part   <= '0;
                  tries  <= '0;
               end
               ST_POLL: if (rd_ok) begin
                  state <= rd_data[0] ? ST_STATUS : ST_WAIT;
               end
               ST_WAIT: if (ms_tick) begin
                  if (tmr_last) begin
                     state  <= ST_IDLE;
                     done_q <= 1'b1;
                     err_q  <= EC_TIMEOUT;
                  end else begin
                     state <= ST_POLL;
                  end
               end
               ST_STATUS: if (rd_ok) begin
                  status_q <= rd_data[15:0];
                  if (topo.topo_bad) begin
                     state  <= ST_IDLE;
                     done_q <= 1'b1;
                     err_q  <= EC_TOPOLOGY;
                  end else if (topo.no_dev) begin
                     state  <= ST_IDLE;
                     done_q <= 1'b1;
                     err_q  <= EC_NO_DEVICES;
                  end else begin
                     count_q <= topo.count;
                     idx     <= '0;
                     state   <= ST_KEY;
                  end
               end
               ST_KEY: if (rd_ok) begin
                  if ({1'b0, idx} == key_total - 1'b1) begin
                     part  <= '0;
                     state <= ST_VPART;
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end
               ST_VPART: if (rd_ok) begin
                  vp_q[int'(part)*32 +: 32] <= rd_data;
                  if (int'(part) == VP_PARTS - 1) state <= ST_HSTART;
                  else                            part  <= part + 1'b1;
               end
               ST_HSTART: state <= ST_HWAIT;
               ST_HWAIT: if (hash_done) begin
                  if (hash_match) begin
                     state  <= ST_IDLE;
                     done_q <= 1'b1;
                     pass_q <= 1'b1;
                  end else if (tries == TRYW'(MAX_TRIES - 1)) begin
                     state  <= ST_IDLE;
                     done_q <= 1'b1;
                     err_q  <= EC_MISMATCH;
                  end else begin
                     tries <= tries + 1'b1;
                     part  <= '0;
                     state <= ST_VPART;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   assign hash_start  = (state == ST_HSTART);
   assign busy        = (state != ST_IDLE);
   assign done        = done_q;
   assign pass        = pass_q;
   assign err_code    = err_q;
   assign dev_count   = count_q;
   assign status_word = status_q;
   assign v_prime     = vp_q;

   // R2
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_ack) |=> (rd_req && $stable(rd_kind) && $stable(rd_index)));

   // R10
   abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_ack && rd_err) |=> (!rd_req && !hash_start && done && err_code == EC_READ_FAULT));

   // R8
   hstart_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hash_start |=> !hash_start);

   // R11
   pass_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pass |-> (done && !busy && err_code == EC_NONE));

   // R11
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !rd_req));

endmodule

// File: tb/repeater_verify_ctrl_bench.sv
module repeater_verify_ctrl_bench;
   localparam int T     = 6;
   localparam int TRIES = 3;
   localparam int IDXW  = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic ms_tick = 1'b0;
   logic rd_req;
   logic [1:0] rd_kind;
   logic [IDXW-1:0] rd_index;
   logic rd_ack = 1'b0;
   logic rd_err = 1'b0;
   logic [31:0] rd_data = '0;
   logic [IDXW-1:0] kbuf_raddr = '0;
   logic [7:0] kbuf_rdata;
   logic [6:0] dev_count;
   logic [15:0] status_word;
   logic [159:0] v_prime;
   logic hash_start;
   logic hash_done = 1'b0;
   logic hash_match = 1'b0;
   logic busy, done, pass;
   logic [2:0] err_code;

   always #2.5 clk = ~clk;

   repeater_verify_ctrl #(.TIMEOUT_MS(T), .MAX_TRIES(TRIES), .KBUF_REG_RD(1'b1)) u_repeater_verify_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .ms_tick(ms_tick),
      .rd_req(rd_req), .rd_kind(rd_kind), .rd_index(rd_index),
      .rd_ack(rd_ack), .rd_err(rd_err), .rd_data(rd_data),
      .kbuf_raddr(kbuf_raddr), .kbuf_rdata(kbuf_rdata),
      .dev_count(dev_count), .status_word(status_word), .v_prime(v_prime),
      .hash_start(hash_start), .hash_done(hash_done), .hash_match(hash_match),
      .busy(busy), .done(done), .pass(pass), .err_code(err_code));

   int n_chk = 0, n_bad = 0;
   int cfg_ready_at, cfg_fail, cfg_inj_kind, cfg_inj_idx;
   bit cfg_inj;
   logic [15:0] cfg_status;
   int poll_n, stat_n, key_n, vp_n, hs_n, order_bad;

   function automatic logic [7:0] key_byte(input int i);
      return 8'((i * 13 + 7) ^ (i >> 3));
   endfunction

   function automatic logic [31:0] vword(input int att, input int p);
      return 32'hC0DE_0000 | 32'(att << 8) | 32'(p);
   endfunction

   task automatic chk(input string req, input string what, input longint got, input longint exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
      end
   endtask

   initial begin
      forever begin
         repeat (19) @(negedge clk);
         ms_tick = 1'b1;
         @(negedge clk);
         ms_tick = 1'b0;
      end
   end

   initial begin
      forever begin
         @(negedge clk);
         if (rd_req) begin
            automatic int k = int'(rd_kind);
            automatic int ix = int'(rd_index);
            automatic logic [31:0] d = '0;
            repeat (2) @(negedge clk);
            case (k)
               0: begin poll_n++; d = {31'd0, (poll_n >= cfg_ready_at)}; end
               1: begin stat_n++; d = {16'd0, cfg_status}; end
               2: begin
                  if (ix != key_n) order_bad++;
                  key_n++;
                  d = {24'd0, key_byte(ix)};
               end
               default: begin
                  if (ix != vp_n % 5) order_bad++;
                  d = vword(vp_n / 5, ix);
                  vp_n++;
               end
            endcase
            rd_ack = 1'b1;
            rd_data = d;
            rd_err = cfg_inj && (k == cfg_inj_kind) && (ix == cfg_inj_idx);
            @(negedge clk);
            rd_ack = 1'b0;
            rd_err = 1'b0;
            rd_data = '0;
         end
      end
   end

   initial begin
      forever begin
         @(negedge clk);
         if (hash_start) begin
            hs_n++;
            repeat (3) @(negedge clk);
            hash_done = 1'b1;
            hash_match = (hs_n > cfg_fail);
            @(negedge clk);
            hash_done = 1'b0;
            hash_match = 1'b0;
         end
      end
   end

   task automatic run(input int ready_at, input logic [15:0] st, input int nfail,
                      input bit inj, input int inj_kind, input int inj_idx);
      int cnt, exp_err, exp_poll, exp_keys, exp_vp, exp_hs, att, kbad;
      bit reach_key, reach_vp;
      cfg_ready_at = ready_at; cfg_status = st; cfg_fail = nfail;
      cfg_inj = inj; cfg_inj_kind = inj_kind; cfg_inj_idx = inj_idx;
      poll_n = 0; stat_n = 0; key_n = 0; vp_n = 0; hs_n = 0; order_bad = 0;
      cnt = int'(st[6:0]);
      reach_key = 0; reach_vp = 0;
      exp_poll = (ready_at > T) ? T : ready_at;
      if (inj && inj_kind == 0) begin exp_err = 5; exp_poll = 1; end
      else if (ready_at > T) exp_err = 1;
      else if (inj && inj_kind == 1) exp_err = 5;
      else if (st[7] || st[11]) exp_err = 2;
      else if (cnt == 0) exp_err = 3;
      else begin
         reach_key = 1;
         if (inj && inj_kind == 2 && inj_idx < cnt * 5) exp_err = 5;
         else begin
            reach_vp = 1;
            if (inj && inj_kind == 3) exp_err = 5;
            else exp_err = (nfail >= TRIES) ? 4 : 0;
         end
      end
      exp_keys = !reach_key ? 0 : ((inj && inj_kind == 2) ? inj_idx + 1 : cnt * 5);
      exp_hs = (reach_vp && !inj) ? ((nfail + 1 < TRIES) ? nfail + 1 : TRIES) : 0;
      exp_vp = !reach_vp ? 0 : (inj ? inj_idx + 1 : 5 * exp_hs);

      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      for (int w = 0; w < 20000 && !done; w++) @(negedge clk);
      repeat (3) @(negedge clk);

      chk("R11", "done", done, 1);
      chk("R11", "busy", busy, 0);
      chk(exp_err == 0 ? "R9" : (exp_err == 1 ? "R4" : (exp_err == 2 ? "R5" :
          (exp_err == 3 ? "R6" : (exp_err == 4 ? "R9" : "R10")))), "err_code", err_code, exp_err);
      chk("R9", "pass", pass, exp_err == 0);
      chk("R3", "polls", poll_n, exp_poll);
      chk("R7", "key reads", key_n, exp_keys);
      chk("R8", "vprime reads", vp_n, exp_vp);
      chk("R9", "hash starts", hs_n, exp_hs);
      chk("R2", "index order", order_bad, 0);
      if (reach_key) begin
         chk("R7", "dev_count", dev_count, cnt);
         chk("R7", "status_word", status_word, st);
      end
      if (reach_vp && !inj) begin
         kbad = 0;
         for (int i = 0; i < cnt * 5; i++) begin
            kbuf_raddr = IDXW'(i);
            @(negedge clk);
            if (kbuf_rdata != key_byte(i)) kbad++;
         end
         chk("R7", "key buffer mismatches", kbad, 0);
         att = exp_hs - 1;
         for (int p = 0; p < 5; p++)
            chk("R8", "v_prime part", v_prime[p*32 +: 32], vword(att, p));
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "busy", busy, 0);
      chk("R1", "done", done, 0);
      chk("R1", "pass", pass, 0);
      chk("R1", "err_code", err_code, 0);
      chk("R1", "rd_req", rd_req, 0);
      chk("R1", "hash_start", hash_start, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int c = 1; c <= 12; c++)
         run((c % T) + 1, {8'h00, 1'b0, 7'(c)}, c % 3, 0, 0, 0);
      run(1, 16'h007F, 0, 0, 0, 0);
      run(T, 16'h0003, 1, 0, 0, 0);          // R4 boundary: ready on last poll
      run(T + 1, 16'h0003, 0, 0, 0, 0);      // R4 timeout
      run(1000, 16'h0003, 0, 0, 0, 0);       // R4 never ready
      for (int b7 = 0; b7 < 2; b7++)
         for (int b3 = 0; b3 < 2; b3++)
            for (int n = 0; n < 2; n++)
               run(2, {4'h0, 1'(b3), 3'h0, 1'(b7), 7'(n * 4)}, 0, 0, 0, 0); // R5 R6
      run(1, 16'hF704, 0, 0, 0, 0);          // R5 other byte-1 bits ignored
      run(1, 16'h0002, 3, 0, 0, 0);          // R9 all attempts mismatch
      run(2, 16'h0002, 7, 0, 0, 0);          // R9
      run(3, 16'h0003, 0, 1, 0, 0);          // R10 poll error
      run(1, 16'h0003, 0, 1, 1, 0);          // R10 status error
      run(1, 16'h0003, 0, 1, 2, 7);          // R10 key error
      run(1, 16'h0003, 0, 1, 3, 2);          // R10 vprime error
      run(1, 16'h0001, 2, 0, 0, 0);          // R9 pass on last attempt

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule